// File: doc/BRIEF.md
# Grouped MSI Vector Interrupt Controller

This block collects message-signalled interrupts for 32 vectors and turns them into eight interrupt lines. Each inbound doorbell write carries a vector number; the block latches one pending bit for that vector. The vectors are dealt out across eight groups of four bits in an interleaved fashion: group g, bit b stands for vector g + 8*b, so group 0 covers vectors 0, 8, 16 and 24, and group 7 covers 7, 15, 23 and 31.

Software reaches the block over a simple 32-bit register bus with a write strobe, a read strobe and a 12-bit byte address. Per group there is a pending register (write 1 to clear), an enable-set register and an enable-clear register. Each group drives its own interrupt line, high while any enabled bit is pending. A shared end-of-interrupt register, written with the group number plus 4, pulls that group's line low for one cycle so that an edge-triggered interrupt input sees a fresh rising edge if work remains. Doorbells arrive either from a dedicated inbound port or through a bus write to the doorbell offset.

Top module: `msivc_top`

## Requirements
- R1: After reset every pending bit and every enable bit is 0, `irq_o` is 0 and `bus_rdata` is 0.
- R2: A doorbell with data v (on the inbound port, or a bus write to offset 0x054) sets the pending bit of vector v[4:0], which is group v[2:0], bit v[4:3]; data bits 31..5 are ignored. Bus and inbound doorbells in the same cycle both take effect.
- R3: A read of the pending register of group g at offset 0x104 + 0x10*g returns the four pending bits in bits 3..0 (bit b = vector g + 8*b) and zeros above, whatever the enable state.
- R4: A bus write to the pending register of group g clears each pending bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R5: A bus write to offset 0x108 + 0x10*g sets, and to 0x10C + 0x10*g clears, each enable bit of group g whose data bit is 1; a read of either offset returns the group's enable bits in bits 3..0.
- R6: `irq_o[g]` is 1 in the cycle after any edge at which group g holds a bit that is both pending and enabled, and 0 otherwise, apart from R7.
- R7: A bus write of value g + 4 (g in 0..7) to offset 0x050 holds `irq_o[g]` low for exactly the one cycle after that write's edge and touches no other group; any other value written there has no effect.
- R8: When a doorbell sets a bit and a write-1-to-clear hits the same bit in the same cycle, the bit ends up pending.
- R9: Read data appears on `bus_rdata` in the cycle after the edge that samples `bus_rd_en`; addresses that are not a pending or enable register read as 0.
- R10: `bus_rdata` holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msi_wr_en | input | 1 | Inbound doorbell write strobe |
| msi_wr_data | input | 32 | Inbound doorbell data, vector number in bits 4..0 |
| bus_wr_en | input | 1 | Register bus write strobe |
| bus_rd_en | input | 1 | Register bus read strobe |
| bus_addr | input | 12 | Register bus byte address |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data, registered |
| irq_o | output | 8 | One interrupt line per group |

## Verification
A pending or enable bit stored in the wrong group or position shows on the next read of that group's register and on the affected `irq_o` line one cycle after the corrupting edge, so the reference model compared on every clock catches it within a cycle. A wrong end-of-interrupt decode shows as a missing or misplaced one-cycle dip on a line whose group still has enabled work. A collision between a doorbell and a clear is observed through the following read of the pending register.

// File: rtl/msivc_pkg.sv
package msivc_pkg;
  localparam int unsigned EOI_OFS      = 32'h050;
  localparam int unsigned DOORBELL_OFS = 32'h054;
  localparam int unsigned PEND_OFS     = 32'h104;
  localparam int unsigned ENSET_OFS    = 32'h108;
  localparam int unsigned ENCLR_OFS    = 32'h10C;
  localparam int unsigned GRP_STRIDE   = 32'h010;
  localparam int unsigned EOI_CODE_BASE = 4;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_PEND = 2'd1,
    RSEL_EN   = 2'd2
  } rsel_e;
endpackage

// File: rtl/msivc_decode.sv
module msivc_decode
  import msivc_pkg::*;
#(
  parameter int NUM_GRP = 8,
  parameter int GRP_BITS = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                         msi_wr_en,
  input  logic [DATA_W-1:0]            msi_wr_data,
  input  logic                         bus_wr_en,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [NUM_GRP*GRP_BITS-1:0]  set_mask,
  output logic [NUM_GRP*GRP_BITS-1:0]  clr_mask,
  output logic [NUM_GRP*GRP_BITS-1:0]  ens_mask,
  output logic [NUM_GRP*GRP_BITS-1:0]  enc_mask,
  output logic [NUM_GRP-1:0]           eoi_hit
);
  localparam int NVEC  = NUM_GRP * GRP_BITS;
  localparam int VEC_W = $clog2(NVEC);

  logic              bus_db;
  logic              bus_eoi;
  logic [VEC_W-1:0]  bus_vec;
  logic [VEC_W-1:0]  msi_vec;

  assign bus_db  = bus_wr_en && (bus_addr == ADDR_W'(DOORBELL_OFS));
  assign bus_eoi = bus_wr_en && (bus_addr == ADDR_W'(EOI_OFS));
  assign bus_vec = bus_wdata[VEC_W-1:0];
  assign msi_vec = msi_wr_data[VEC_W-1:0];

  // Doorbell decode: vector index g + NUM_GRP*b lands in group g, bit b.
  always_comb begin
    set_mask = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int b = 0; b < GRP_BITS; b++) begin
        if (bus_db && (bus_vec == VEC_W'(g + NUM_GRP * b)))
          set_mask[g*GRP_BITS + b] = 1'b1;
        if (msi_wr_en && (msi_vec == VEC_W'(g + NUM_GRP * b)))
          set_mask[g*GRP_BITS + b] = 1'b1;
      end
    end
  end

  // Per-group register writes.
  always_comb begin
    clr_mask = '0;
    ens_mask = '0;
    enc_mask = '0;
    eoi_hit  = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (bus_wr_en && (bus_addr == ADDR_W'(PEND_OFS + GRP_STRIDE * g)))
        clr_mask[g*GRP_BITS +: GRP_BITS] = bus_wdata[GRP_BITS-1:0];
      if (bus_wr_en && (bus_addr == ADDR_W'(ENSET_OFS + GRP_STRIDE * g)))
        ens_mask[g*GRP_BITS +: GRP_BITS] = bus_wdata[GRP_BITS-1:0];
      if (bus_wr_en && (bus_addr == ADDR_W'(ENCLR_OFS + GRP_STRIDE * g)))
        enc_mask[g*GRP_BITS +: GRP_BITS] = bus_wdata[GRP_BITS-1:0];
      if (bus_eoi && (bus_wdata == DATA_W'(EOI_CODE_BASE + g)))
        eoi_hit[g] = 1'b1;
    end
  end
endmodule

// File: rtl/msivc_group.sv
module msivc_group #(
  parameter int GRP_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [GRP_BITS-1:0] set_i,
  input  logic [GRP_BITS-1:0] clr_i,
  input  logic [GRP_BITS-1:0] ens_i,
  input  logic [GRP_BITS-1:0] enc_i,
  input  logic                eoi_i,
  output logic [GRP_BITS-1:0] pend_o,
  output logic [GRP_BITS-1:0] en_o,
  output logic                irq_o
);
  logic [GRP_BITS-1:0] pend_q, pend_d;
  logic [GRP_BITS-1:0] en_q, en_d;
  logic                mute_q, mute_d;
  logic                pend_ce, en_ce, mute_ce;

  // Next state: a doorbell set overrides a same-cycle clear.
  always_comb begin
    pend_d  = (pend_q & ~clr_i) | set_i;
    pend_ce = |(set_i | clr_i);
    en_d    = (en_q | ens_i) & ~enc_i;
    en_ce   = |(ens_i | enc_i);
    mute_d  = eoi_i;
    mute_ce = eoi_i | mute_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      mute_q <= 1'b0;
    end else begin
      if (pend_ce) pend_q <= pend_d;
      if (en_ce)   en_q   <= en_d;
      if (mute_ce) mute_q <= mute_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = (|(pend_q & en_q)) & ~mute_q;

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  assert_enable_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ens_i) |=> ((en_q & $past(ens_i)) == $past(ens_i)));

  assert_eoi_dip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_i |=> !irq_o);

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(pend_q & en_q)));
endmodule

// File: rtl/msivc_top.sv
module msivc_top
  import msivc_pkg::*;
#(
  parameter int NUM_GRP = 8,
  parameter int GRP_BITS = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_wr_en,
  input  logic [DATA_W-1:0] msi_wr_data,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_GRP-1:0] irq_o
);
  localparam int NVEC = NUM_GRP * GRP_BITS;

  logic              rst_s1_q, rst_s2_q;
  logic              rst_int_n;
  logic [NVEC-1:0]   set_mask, clr_mask, ens_mask, enc_mask;
  logic [NUM_GRP-1:0] eoi_hit;
  logic [NVEC-1:0]   pend_all, en_all;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;
  rsel_e             rsel;
  logic [$clog2(NUM_GRP)-1:0] rgrp;

  // Reset: asserted at once, released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  msivc_decode #(
    .NUM_GRP(NUM_GRP), .GRP_BITS(GRP_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_decode (
    .msi_wr_en  (msi_wr_en),
    .msi_wr_data(msi_wr_data),
    .bus_wr_en  (bus_wr_en),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .set_mask   (set_mask),
    .clr_mask   (clr_mask),
    .ens_mask   (ens_mask),
    .enc_mask   (enc_mask),
    .eoi_hit    (eoi_hit)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    msivc_group #(.GRP_BITS(GRP_BITS)) u_grp (
      .clk   (clk),
      .rst_n (rst_int_n),
      .set_i (set_mask[g*GRP_BITS +: GRP_BITS]),
      .clr_i (clr_mask[g*GRP_BITS +: GRP_BITS]),
      .ens_i (ens_mask[g*GRP_BITS +: GRP_BITS]),
      .enc_i (enc_mask[g*GRP_BITS +: GRP_BITS]),
      .eoi_i (eoi_hit[g]),
      .pend_o(pend_all[g*GRP_BITS +: GRP_BITS]),
      .en_o  (en_all[g*GRP_BITS +: GRP_BITS]),
      .irq_o (irq_o[g])
    );
  end

  // Read address decode.
  always_comb begin
    rsel = RSEL_NONE;
    rgrp = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (bus_addr == ADDR_W'(PEND_OFS + GRP_STRIDE * g)) begin
        rsel = RSEL_PEND;
        rgrp = g[$clog2(NUM_GRP)-1:0];
      end
      if ((bus_addr == ADDR_W'(ENSET_OFS + GRP_STRIDE * g)) ||
          (bus_addr == ADDR_W'(ENCLR_OFS + GRP_STRIDE * g))) begin
        rsel = RSEL_EN;
        rgrp = g[$clog2(NUM_GRP)-1:0];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (rsel)
      RSEL_PEND: rd_val[GRP_BITS-1:0] = pend_all[rgrp*GRP_BITS +: GRP_BITS];
      RSEL_EN:   rd_val[GRP_BITS-1:0] = en_all[rgrp*GRP_BITS +: GRP_BITS];
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else if (bus_rd_en) rdata_q <= rd_val;
  end
  assign bus_rdata = rdata_q;

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd_en |=> $stable(bus_rdata));

  assert_rdata_width_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_rd_en |=> (bus_rdata[DATA_W-1:GRP_BITS] == '0));
endmodule

// File: tb/sim_msivc_top.sv
module sim_msivc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        msi_wr_en;
  logic [31:0] msi_wr_data;
  logic        bus_wr_en;
  logic        bus_rd_en;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_o;

  int n_checks = 0;
  int n_fail = 0;

  logic [3:0]  m_pend [NG];
  logic [3:0]  m_en   [NG];
  logic        m_mute [NG];
  logic [31:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  msivc_top u0 (
    .clk(clk), .rst_n(rst_n),
    .msi_wr_en(msi_wr_en), .msi_wr_data(msi_wr_data),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [7:0] m_irq();
    logic [7:0] r;
    for (int g = 0; g < NG; g++) r[g] = (|(m_pend[g] & m_en[g])) & ~m_mute[g];
    return r;
  endfunction

  // Behavioural reference model, updated at each edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin
        m_pend[g] = 4'h0; m_en[g] = 4'h0; m_mute[g] = 1'b0;
      end
      m_rdata = 32'h0;
    end else begin
      logic [3:0] np [NG];
      logic [3:0] ne [NG];
      logic       nm [NG];
      for (int g = 0; g < NG; g++) begin
        np[g] = m_pend[g]; ne[g] = m_en[g]; nm[g] = 1'b0;
      end
      if (bus_rd_en) begin
        int a;
        a = int'(bus_addr);
        m_rdata = 32'h0;
        if (a >= 'h104 && a < 'h184) begin
          if (a % 16 == 4) m_rdata = {28'h0, m_pend[(a - 'h104) / 16]};
          else if (a % 16 == 8 || a % 16 == 12) m_rdata = {28'h0, m_en[(a - 'h104) / 16]};
        end
      end
      if (bus_wr_en) begin
        int a;
        a = int'(bus_addr);
        if (a >= 'h104 && a < 'h184) begin
          if (a % 16 == 4) np[(a - 'h104) / 16] = np[(a - 'h104) / 16] & ~bus_wdata[3:0];
          else if (a % 16 == 8) ne[(a - 'h104) / 16] = ne[(a - 'h104) / 16] | bus_wdata[3:0];
          else if (a % 16 == 12) ne[(a - 'h104) / 16] = ne[(a - 'h104) / 16] & ~bus_wdata[3:0];
        end
        if (a == 'h050 && bus_wdata >= 4 && bus_wdata <= 11) nm[bus_wdata - 4] = 1'b1;
      end
      if (bus_wr_en && bus_addr == 12'h054)
        np[bus_wdata % 8][(bus_wdata / 8) % 4] = 1'b1;
      if (msi_wr_en)
        np[msi_wr_data % 8][(msi_wr_data / 8) % 4] = 1'b1;
      for (int g = 0; g < NG; g++) begin
        m_pend[g] = np[g]; m_en[g] = ne[g]; m_mute[g] = nm[g];
      end
    end
  end

  // Continuous comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if (irq_o !== m_irq()) begin
        n_fail++;
        $display("FAIL R6 irq_o actual %h expected %h at %0t", irq_o, m_irq(), $time);
      end
      n_checks++;
      if (bus_rdata !== m_rdata) begin
        n_fail++;
        $display("FAIL R9 bus_rdata actual %h expected %h at %0t", bus_rdata, m_rdata, $time);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic msi(input logic [31:0] d);
    @(negedge clk);
    msi_wr_en = 1'b1; msi_wr_data = d;
    @(negedge clk);
    msi_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    chk(bus_rdata, exp, tag);
  endtask

  function automatic logic [11:0] pend_a(input int g); return 12'(32'h104 + 16*g); endfunction
  function automatic logic [11:0] ens_a(input int g);  return 12'(32'h108 + 16*g); endfunction
  function automatic logic [11:0] enc_a(input int g);  return 12'(32'h10C + 16*g); endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    msi_wr_en = 1'b0; msi_wr_data = '0;
    bus_wr_en = 1'b0; bus_rd_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk({24'h0, irq_o}, 32'h0, "R1 irq after reset");
    chk(bus_rdata, 32'h0, "R1 rdata after reset");
    bus_rd(pend_a(0), 32'h0, "R1 pending after reset");
    bus_rd(ens_a(7), 32'h0, "R1 enable after reset");

    msi(32'd13);                        // group 5, bit 1
    bus_rd(pend_a(5), 32'h2, "R2 inbound vector 13");
    msi(32'h0000_0123);                 // low bits 3: group 3, bit 0
    bus_rd(pend_a(3), 32'h1, "R2 upper data bits ignored");
    chk({24'h0, irq_o}, 32'h0, "R3 pending without enable gives no irq");
    bus_rd(pend_a(5), 32'h2, "R3 raw pending read while disabled");

    bus_wr(ens_a(5), 32'hF);
    chk({31'h0, irq_o[5]}, 32'h1, "R6 irq after enable");
    bus_rd(ens_a(5), 32'hF, "R5 enable-set readback");
    bus_rd(enc_a(5), 32'hF, "R5 enable-clear readback");

    bus_wr(12'h050, 32'd9);             // group 5
    chk({31'h0, irq_o[5]}, 32'h0, "R7 dip after end-of-interrupt");
    @(negedge clk);
    chk({31'h0, irq_o[5]}, 32'h1, "R7 line returns after one cycle");
    bus_wr(12'h050, 32'd3);
    chk({31'h0, irq_o[5]}, 32'h1, "R7 out-of-range code ignored");

    bus_wr(enc_a(5), 32'h2);
    chk({31'h0, irq_o[5]}, 32'h0, "R5 clear enable drops irq");
    bus_rd(ens_a(5), 32'hD, "R5 enable after clear");

    bus_wr(pend_a(3), 32'h1);
    bus_rd(pend_a(3), 32'h0, "R4 write-1 clears");
    bus_wr(pend_a(5), 32'h0);
    bus_rd(pend_a(5), 32'h2, "R4 write-0 leaves bits");

    @(negedge clk);                      // doorbell vector 11 and clear in one cycle
    msi_wr_en = 1'b1; msi_wr_data = 32'd11;
    bus_wr_en = 1'b1; bus_addr = pend_a(3); bus_wdata = 32'h2;
    @(negedge clk);
    msi_wr_en = 1'b0; bus_wr_en = 1'b0;
    bus_rd(pend_a(3), 32'h2, "R8 set beats clear");

    bus_wr(12'h054, 32'd31);            // group 7, bit 3
    bus_rd(pend_a(7), 32'h8, "R2 bus doorbell vector 31");
    @(negedge clk);                      // two doorbells in one cycle
    msi_wr_en = 1'b1; msi_wr_data = 32'd1;
    bus_wr_en = 1'b1; bus_addr = 12'h054; bus_wdata = 32'd9;
    @(negedge clk);
    msi_wr_en = 1'b0; bus_wr_en = 1'b0;
    bus_rd(pend_a(1), 32'h3, "R2 simultaneous doorbells");

    bus_rd(12'h0A0, 32'h0, "R9 unmapped read");
    bus_rd(pend_a(7), 32'h8, "R9 read latency");
    repeat (3) @(negedge clk);
    chk(bus_rdata, 32'h8, "R10 rdata held");

    for (int v = 0; v < 32; v++) msi(32'(v));
    for (int g = 0; g < NG; g++) begin
      bus_rd(pend_a(g), 32'hF, "R2 all vectors pending");
      bus_wr(ens_a(g), 32'hF);
    end
    chk({24'h0, irq_o}, 32'hFF, "R6 all lines high");
    for (int g = 0; g < NG; g++) bus_wr(pend_a(g), 32'hF);
    chk({24'h0, irq_o}, 32'h0, "R4 all cleared, lines low");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule